// File: doc/BRIEF.md
# Three-Phase Dead-Time Generator

This block sits in front of a three-phase half-bridge gate driver and produces, for each phase, a high-side and a low-side gate enable that are never on together. In single-line mode each phase takes one PWM level. The block derives two complementary enables from it and inserts a programmable off gap at every transition. The side that is on drops at once, and the opposite side comes on only after the gap has run out with the input held steady.

In individual mode the high-side and low-side requests of each phase pass through on their own. A fixed two-cycle off floor still guards every switch-over. A request for both sides at once is treated as a request for neither. A small configuration register holds the gap count and a drive-strength code. The strength code is only presented on an output for the analog driver stage.

Top module: `dead_time_gen`

## Requirements
- R1: While the active-high synchronous reset `rst` is high, all six gate enables are driven low after the next clock edge, the gap count reloads to 4 and `drive_strength` reloads to 2.
- R2: A cycle with `cfg_we` high loads `cfg_gap` and `cfg_strength` at that clock edge. `drive_strength` shows the new code from the next cycle and keeps it until the next write or reset.
- R3: In single-line mode, a rise of `pwm_in[i]` sampled at edge k clears both enables of phase i after edge k. `gate_hs[i]` turns on after edge k+G, where G is the effective gap.
- R4: In single-line mode, a fall of `pwm_in[i]` is the mirror of R3: both enables are off for G cycles, and then `gate_ls[i]` turns on.
- R5: The effective gap G in single-line mode is the larger of the programmed count and 2, so a count of 0 or 1 behaves as 2.
- R6: If the single-line input of a phase changes again before its gap has run out, the gap restarts from that change. Both enables stay off until G cycles have passed with the input steady.
- R7: In individual mode, a change of a phase's requested side turns its enables off after the sampling edge. The requested enable comes on two cycles later, and the programmed count plays no part.
- R8: In individual mode, when `hs_in[i]` and `ls_in[i]` are both high, both enables of phase i are held off until only one request remains. The other phases are unaffected.
- R9: `gate_hs[i]` and `gate_ls[i]` are never high in the same cycle, in either mode.
- R10: A programmed gap of 15 has no effect in individual mode; the gap there stays at 2 cycles.
- R11: Each phase keeps its own gap timing. A transition on one phase leaves the enables of the other phases unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one gap count per cycle |
| rst | input | 1 | Synchronous reset, active high |
| single_mode | input | 1 | 1 = one PWM level per phase, 0 = separate high/low requests |
| cfg_we | input | 1 | Loads the configuration register |
| cfg_gap | input | 4 | Gap count to load (0 to 15 cycles) |
| cfg_strength | input | 2 | Drive-strength code to load |
| pwm_in | input | 3 | Single-line PWM level, one bit per phase |
| hs_in | input | 3 | Individual-mode high-side request per phase |
| ls_in | input | 3 | Individual-mode low-side request per phase |
| gate_hs | output | 3 | High-side gate enable per phase |
| gate_ls | output | 3 | Low-side gate enable per phase |
| drive_strength | output | 2 | Stored drive-strength code |

## Verification
Single-line edges are driven with the default gap, with counts of 0 and 1, and with a count of 7. This separates a gap that honours the programmed value from one that ignores the two-cycle floor. A toggle back before the gap ends shows whether the counter restarts or only resumes. A one-phase change, with the other phases held steady, exposes any coupling between the phases. In individual mode, swapping the requests while a count of 15 is loaded shows that only the fixed floor applies. Overlapping requests show that the conflicting phase is forced off while the other phases keep running.

// File: rtl/dead_time_gen.sv
module dead_time_gen #(
  parameter int PHASES  = 3,
  parameter int GAP_W   = 4,
  parameter int FLOOR   = 2,
  parameter int DEF_GAP = 4,
  parameter int STR_W   = 2,
  parameter int DEF_STR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              single_mode,
  input  logic              cfg_we,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [STR_W-1:0]  cfg_strength,
  input  logic [PHASES-1:0] pwm_in,
  input  logic [PHASES-1:0] hs_in,
  input  logic [PHASES-1:0] ls_in,
  output logic [PHASES-1:0] gate_hs,
  output logic [PHASES-1:0] gate_ls,
  output logic [STR_W-1:0]  drive_strength
);
  localparam int CNT_W = GAP_W + 1;

  logic [GAP_W-1:0] gap_q;
  logic [STR_W-1:0] str_q;
  logic [CNT_W-1:0] gap_ext, gap_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GAP_W'(DEF_GAP);
      str_q <= STR_W'(DEF_STR);
    end else if (cfg_we) begin
      gap_q <= cfg_gap;
      str_q <= cfg_strength;
    end
  end

  assign drive_strength = str_q;
  assign gap_ext = {1'b0, gap_q};
  assign gap_eff = (single_mode && gap_ext > CNT_W'(FLOOR)) ? gap_ext : CNT_W'(FLOOR);

  for (genvar i = 0; i < PHASES; i++) begin : g_ph
    logic             want_h, want_l, held_h, held_l, hs_q, ls_q;
    logic [CNT_W-1:0] cnt;

    assign want_h = single_mode ?  pwm_in[i] : (hs_in[i] & ~ls_in[i]);
    assign want_l = single_mode ? ~pwm_in[i] : (ls_in[i] & ~hs_in[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        {held_h, held_l, hs_q, ls_q} <= '0;
        cnt <= '0;
      end else if ({want_h, want_l} != {held_h, held_l}) begin
        {held_h, held_l} <= {want_h, want_l};
        {hs_q, ls_q}     <= 2'b00;
        cnt              <= CNT_W'(1);
      end else if (cnt < gap_eff) begin
        cnt <= cnt + CNT_W'(1);
      end else begin
        hs_q <= held_h;
        ls_q <= held_l;
      end
    end

    assign gate_hs[i] = hs_q;
    assign gate_ls[i] = ls_q;

    // R9: the two switches of a phase never conduct together
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
      !(gate_hs[i] && gate_ls[i]));

    // R3, R4: any single-line edge clears both enables next cycle
    a_r3_break_first: assert property (@(posedge clk) disable iff (rst)
      (single_mode && $past(single_mode) && pwm_in[i] != $past(pwm_in[i]))
      |=> (!gate_hs[i] && !gate_ls[i]));

    // R5, R7: a turn-on is preceded by at least two off cycles of the other side
    a_r5_floor_hs: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hs[i]) |-> (!$past(gate_ls[i]) && !$past(gate_ls[i], 2)));
    a_r5_floor_ls: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_ls[i]) |-> (!$past(gate_hs[i]) && !$past(gate_hs[i], 2)));

    // R8: conflicting individual requests keep the phase dark
    a_r8_conflict_off: assert property (@(posedge clk) disable iff (rst)
      (!single_mode && hs_in[i] && ls_in[i]) |=> (!gate_hs[i] && !gate_ls[i]));
  end

  // R1: reset clears the gates and restores the strength code
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (gate_hs == '0 && gate_ls == '0 && drive_strength == STR_W'(DEF_STR)));

  // R2: the strength code only moves on a write
  a_r2_strength_hold: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !rst) |=> $stable(drive_strength));
endmodule

// File: tb/tb_dead_time_gen.sv
module tb_dead_time_gen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst, single_mode, cfg_we;
  logic [3:0] cfg_gap;
  logic [1:0] cfg_strength;
  logic [2:0] pwm_in, hs_in, ls_in;
  logic [2:0] gate_hs, gate_ls;
  logic [1:0] drive_strength;

  dead_time_gen dut (
    .clk(clk), .rst(rst), .single_mode(single_mode), .cfg_we(cfg_we),
    .cfg_gap(cfg_gap), .cfg_strength(cfg_strength), .pwm_in(pwm_in),
    .hs_in(hs_in), .ls_in(ls_in), .gate_hs(gate_hs), .gate_ls(gate_ls),
    .drive_strength(drive_strength)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [2:0] h; logic [2:0] l; string r; } exp_t;
  exp_t q[$];
  exp_t e;

  logic       s_rst, s_single, s_we;
  logic [3:0] s_gap;
  logic [1:0] s_str;
  logic [2:0] s_pwm, s_hs, s_ls;

  task automatic tick(input logic [2:0] eh, input logic [2:0] el, input string r);
    exp_t it;
    @(negedge clk);
    rst = s_rst; single_mode = s_single; cfg_we = s_we; cfg_gap = s_gap;
    cfg_strength = s_str; pwm_in = s_pwm; hs_in = s_hs; ls_in = s_ls;
    it.h = eh; it.l = el; it.r = r;
    q.push_back(it);
  endtask

  task automatic run(input int n, input logic [2:0] eh, input logic [2:0] el, input string r);
    for (int k = 0; k < n; k++) tick(eh, el, r);
  endtask

  task automatic check_str(input logic [1:0] exp_s, input string r);
    @(posedge clk); #3;
    checks++;
    if (drive_strength !== exp_s) begin
      errors++;
      $display("FAIL %s: drive_strength=%0d expected %0d", r, drive_strength, exp_s);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (gate_hs !== e.h || gate_ls !== e.l) begin
          errors++;
          $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", e.r, gate_hs, gate_ls, e.h, e.l);
        end
        checks++;
        if ((gate_hs & gate_ls) !== 3'b000) begin
          errors++;
          $display("FAIL R9: overlap hs=%b ls=%b expected no common bit", gate_hs, gate_ls);
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    s_rst = 1; s_single = 1; s_we = 0; s_gap = 0; s_str = 0;
    s_pwm = 0; s_hs = 0; s_ls = 0;
    rst = 1; single_mode = 1; cfg_we = 0; cfg_gap = 0; cfg_strength = 0;
    pwm_in = 0; hs_in = 0; ls_in = 0;

    run(2, 3'b000, 3'b000, "R1");
    s_rst = 0;
    run(4, 3'b000, 3'b000, "R1");
    run(2, 3'b000, 3'b111, "R1");
    check_str(2'd2, "R1");

    s_pwm = 3'b111;
    run(4, 3'b000, 3'b000, "R3");
    run(2, 3'b111, 3'b000, "R3");

    s_pwm = 3'b000;
    run(4, 3'b000, 3'b000, "R4");
    run(2, 3'b000, 3'b111, "R4");

    s_we = 1; s_gap = 0; s_str = 2'd1;
    tick(3'b000, 3'b111, "R2");
    s_we = 0;
    run(1, 3'b000, 3'b111, "R2");
    check_str(2'd1, "R2");

    s_pwm = 3'b111;
    run(2, 3'b000, 3'b000, "R5");
    run(2, 3'b111, 3'b000, "R5");
    s_we = 1; s_gap = 1;
    tick(3'b111, 3'b000, "R5");
    s_we = 0; s_pwm = 3'b000;
    run(2, 3'b000, 3'b000, "R5");
    run(2, 3'b000, 3'b111, "R5");

    s_we = 1; s_gap = 7;
    tick(3'b000, 3'b111, "R3");
    s_we = 0; s_pwm = 3'b111;
    run(7, 3'b000, 3'b000, "R3");
    run(2, 3'b111, 3'b000, "R3");

    s_we = 1; s_gap = 4;
    tick(3'b111, 3'b000, "R6");
    s_we = 0; s_pwm = 3'b000;
    run(2, 3'b000, 3'b000, "R6");
    s_pwm = 3'b111;
    run(4, 3'b000, 3'b000, "R6");
    run(2, 3'b111, 3'b000, "R6");

    s_pwm = 3'b110;
    run(4, 3'b110, 3'b000, "R11");
    run(2, 3'b110, 3'b001, "R11");

    s_we = 1; s_gap = 15;
    tick(3'b110, 3'b001, "R10");
    s_we = 0; s_single = 0; s_hs = 3'b110; s_ls = 3'b001;
    run(3, 3'b110, 3'b001, "R7");
    s_hs = 3'b001; s_ls = 3'b110;
    run(2, 3'b000, 3'b000, "R10");
    run(2, 3'b001, 3'b110, "R10");

    s_hs = 3'b111; s_ls = 3'b110;
    run(4, 3'b001, 3'b000, "R8");
    s_hs = 3'b001; s_ls = 3'b110;
    run(2, 3'b001, 3'b000, "R8");
    run(2, 3'b001, 3'b110, "R8");

    s_rst = 1;
    tick(3'b000, 3'b000, "R1");
    check_str(2'd2, "R1");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule